// File: doc/BRIEF.md
# Pulsed Overcurrent Protection Controller

This block sits beside a supply regulator and decides when the regulator output may drive its load. It watches a digital overload comparator and a digital over-temperature comparator, and it drives one output-enable line plus two status flags: one for overload and one for overheating. All timing comes from a millisecond tick, which a prescaler derives from the system clock.

Two protection styles are selectable. In dynamic (hiccup) style, an overload turns the output off for a long window and then back on for a short retry window that is one tenth as long. The cycle repeats until a whole retry window passes with no overload. In static (clamp) style, the output stays on, the analog current limit does the clamping, and the overload flag simply mirrors the comparator. Over-temperature overrides both styles. Dropping the enable or losing the supply forces the output off and clears the sequence.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: A tick is produced once every TICK_DIV clock cycles, counted from reset release. The first tick falls on the clock edge that ends cycle TICK_DIV after reset, and all timing below is quantised to these ticks.
- R2: In dynamic style (`clamp_static` = 0) with the output on in normal operation, any overload seen in a cycle is acted on at the next tick edge. On that edge `out_enable` falls and `overload_flag` rises together. If the overload is seen in the tick cycle itself, that same edge acts on it.
- R3: The off window lasts exactly OFF_TICKS ticks (OFF_TICKS × TICK_DIV cycles). During the whole window `out_enable` is 0 and `overload_flag` is 1.
- R4: The retry window follows at once and lasts ON_TICKS = OFF_TICKS/10 ticks, with `out_enable` 1 and `overload_flag` still 1. If the overload input was high in any cycle of the window, even a single one, a new off window starts at the window's last edge.
- R5: If a retry window ends with no overload seen, normal operation resumes. `overload_flag` clears on the window's last edge and `out_enable` stays 1.
- R6: In static style, `out_enable` is 1 and `overload_flag` equals the overload input of the previous cycle.
- R7: Going from static to dynamic style while an overload is present turns the output off at the next tick, within 1 to TICK_DIV cycles. Going from dynamic to static style abandons any hiccup sequence: `out_enable` is 1 and the flag follows the input from the next cycle.
- R8: Over-temperature has priority over everything else. One cycle after `overheat_det` rises, `out_enable` is 0, `overheat_flag` is 1 and `overload_flag` is 0, and the hiccup sequence is reset. One cycle after it falls, `overheat_flag` is 0 and normal operation resumes with the output on.
- R9: When `pwr_enable` or `supply_good` is low, `out_enable` and `overload_flag` are 0 from the next cycle and the sequence is reset. Restoring both turns the output on in the next cycle. `overheat_flag` still tracks its input during this time.
- R10: During reset all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_enable | input | 1 | Output allowed when high |
| supply_good | input | 1 | Input supply above its lockout level |
| clamp_static | input | 1 | 1 selects static clamp style, 0 selects hiccup style |
| overload_det | input | 1 | Overload comparator, active high |
| overheat_det | input | 1 | Over-temperature comparator (hysteresis outside), active high |
| out_enable | output | 1 | Regulator output enable |
| overload_flag | output | 1 | Overload status |
| overheat_flag | output | 1 | Over-temperature status |

## Verification
The bench runs with a four-cycle tick and a thirty-tick off window. It uses the edge where the overload flag clears, which is always a tick edge, as a phase reference, and it sweeps a one-cycle overload pulse across every cycle of a tick period and across every cycle of the retry window. A design that evaluated the comparator only on tick cycles would miss most of those pulses. An off-by-one in the window timer shows up as an off or on time one tick too long or too short. Mode switching during an active overload, over-temperature in the middle of an off window, and loss of enable in the middle of an off window are all checked. A design that kept the hiccup state across those events would leave the output dark when it should be on.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_OFF   = 2'd1,
    ST_RETRY = 2'd2
  } ocp_state_e;
endpackage

// File: rtl/ocp_tick_gen.sv
module ocp_tick_gen #(
  parameter int unsigned TICK_DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (TICK_DIV < 2) ? 1 : $clog2(TICK_DIV);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q >= LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CW'(1);
  end

  assign tick = (cnt_q >= LAST);

  generate
    if (TICK_DIV > 1) begin : g_chk
      // R1: ticks never come back to back when the divider exceeds one
      a_r1_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/ocp_window_timer.sv
module ocp_window_timer #(
  parameter int unsigned TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          win_last
);
  logic [TW-1:0] cnt_q;

  assign win_last = tick && (cnt_q == (limit - TW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (tick)     cnt_q <= win_last ? '0 : cnt_q + TW'(1);
  end

  // R3: the window count never reaches the limit selected by the sequencer
  a_r3_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < limit);
endmodule

// File: rtl/ocp_hiccup_fsm.sv
module ocp_hiccup_fsm
  import ocp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic win_last,
  input  logic active,
  input  logic static_mode,
  input  logic overload,
  input  logic overheat,
  output logic timer_clr,
  output logic sel_off,
  output logic out_en,
  output logic ol_flag,
  output logic ot_flag
);
  ocp_state_e st_q, st_n;
  logic seen_q, seen_n, seen_now;
  logic en_q, en_n, ol_q, ol_n, ot_q;
  logic hold;

  assign seen_now = seen_q | overload;
  assign hold     = !active || overheat;

  always_comb begin
    st_n   = st_q;
    seen_n = seen_q;
    en_n   = en_q;
    ol_n   = ol_q;
    if (hold) begin
      st_n = ST_RUN; seen_n = 1'b0; en_n = 1'b0; ol_n = 1'b0;
    end else if (static_mode) begin
      st_n = ST_RUN; seen_n = 1'b0; en_n = 1'b1; ol_n = overload;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          en_n = 1'b1; ol_n = 1'b0;
          if (tick && seen_now) begin
            st_n = ST_OFF; seen_n = 1'b0; en_n = 1'b0; ol_n = 1'b1;
          end else if (tick) begin
            seen_n = 1'b0;
          end else begin
            seen_n = seen_now;
          end
        end
        ST_OFF: begin
          en_n = 1'b0; ol_n = 1'b1; seen_n = 1'b0;
          if (win_last) begin
            st_n = ST_RETRY; en_n = 1'b1;
          end
        end
        ST_RETRY: begin
          en_n = 1'b1; ol_n = 1'b1; seen_n = seen_now;
          if (win_last) begin
            seen_n = 1'b0;
            if (seen_now) begin
              st_n = ST_OFF; en_n = 1'b0;
            end else begin
              st_n = ST_RUN; ol_n = 1'b0;
            end
          end
        end
        default: begin
          st_n = ST_RUN; seen_n = 1'b0; en_n = 1'b0; ol_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      seen_q <= 1'b0;
      en_q   <= 1'b0;
      ol_q   <= 1'b0;
      ot_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      seen_q <= seen_n;
      en_q   <= en_n;
      ol_q   <= ol_n;
      ot_q   <= overheat;
    end
  end

  assign timer_clr = hold || static_mode || (st_q == ST_RUN);
  assign sel_off   = (st_q == ST_OFF);
  assign out_en    = en_q;
  assign ol_flag   = ol_q;
  assign ot_flag   = ot_q;

  // R2: an overload seen by a tick in normal operation trips the output
  a_r2_trip_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !static_mode && st_q == ST_RUN && tick && seen_now)
      |=> (!en_q && ol_q && st_q == ST_OFF));
  // R3: output dark and flag raised for the whole off window
  a_r3_off_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF) |-> (!en_q && ol_q));
  // R5: a clean retry window restores normal operation
  a_r5_clean_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !static_mode && st_q == ST_RETRY && win_last && !seen_now)
      |=> (en_q && !ol_q && st_q == ST_RUN));
  // R6: static style keeps output on, flag mirrors the comparator
  a_r6_static_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && static_mode) |=> (en_q && (ol_q == $past(overload))));
  // R8: over-temperature forces the output off
  a_r8_heat_off: assert property (@(posedge clk) disable iff (!rst_n)
    overheat |=> (!en_q && !ol_q && ot_q));
  // R9: loss of enable or supply forces the output off
  a_r9_inactive_off: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!en_q && !ol_q));
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl #(
  parameter int unsigned TICK_DIV  = 50000,
  parameter int unsigned OFF_TICKS = 900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_enable,
  input  logic supply_good,
  input  logic clamp_static,
  input  logic overload_det,
  input  logic overheat_det,
  output logic out_enable,
  output logic overload_flag,
  output logic overheat_flag
);
  localparam int unsigned ON_TICKS = (OFF_TICKS / 10 < 1) ? 1 : OFF_TICKS / 10;
  localparam int unsigned TW       = $clog2(OFF_TICKS + 1);

  logic tick, win_last, timer_clr, sel_off;
  logic [TW-1:0] limit;

  assign limit = sel_off ? TW'(OFF_TICKS) : TW'(ON_TICKS);

  ocp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  ocp_window_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (timer_clr),
    .tick     (tick),
    .limit    (limit),
    .win_last (win_last)
  );

  ocp_hiccup_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .win_last    (win_last),
    .active      (pwr_enable & supply_good),
    .static_mode (clamp_static),
    .overload    (overload_det),
    .overheat    (overheat_det),
    .timer_clr   (timer_clr),
    .sel_off     (sel_off),
    .out_en      (out_enable),
    .ol_flag     (overload_flag),
    .ot_flag     (overheat_flag)
  );
endmodule

// File: tb/sim_ocp_hiccup_ctrl.sv
module sim_ocp_hiccup_ctrl;
  localparam int DIV  = 4;
  localparam int OFFT = 30;
  localparam int ONT  = OFFT / 10;
  localparam int OFFC = OFFT * DIV;
  localparam int ONC  = ONT * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_enable = 1'b0, supply_good = 1'b0, clamp_static = 1'b0;
  logic overload_det = 1'b0, overheat_det = 1'b0;
  logic out_enable, overload_flag, overheat_flag;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  ocp_hiccup_ctrl #(.TICK_DIV(DIV), .OFF_TICKS(OFFT)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_enable(pwr_enable), .supply_good(supply_good),
    .clamp_static(clamp_static), .overload_det(overload_det), .overheat_det(overheat_det),
    .out_enable(out_enable), .overload_flag(overload_flag), .overheat_flag(overheat_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic nxt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts cycles for which the chosen output keeps value v (sel 0: enable, 1: overload flag)
  task automatic run_len(input int sel, input logic v, output int n);
    n = 0;
    while (((sel == 0) ? out_enable : overload_flag) == v) begin
      @(negedge clk);
      n++;
    end
  endtask

  // at the first dark cycle: measure off window, then clean retry window
  task automatic off_then_clean(input string tag);
    int n;
    run_len(0, 1'b0, n);
    chk({tag, " R3 off length"}, n, OFFC);
    chk({tag, " R4 flag held in retry"}, overload_flag, 1);
    run_len(1, 1'b1, n);
    chk({tag, " R5 clean retry length"}, n, ONC);
    chk({tag, " R5 output stays on"}, out_enable, 1);
  endtask

  // from any normal state: force a trip, release, land on a flag-clear edge
  task automatic resync();
    overload_det = 1'b1;
    while (out_enable) @(negedge clk);
    overload_det = 1'b0;
    off_then_clean("resync");
  endtask

  // at a flag-clear edge S: pulse at S+j, expect the trip at S+DIV
  task automatic trip_at(input int j);
    nxt(j);
    overload_det = 1'b1;
    nxt(1);
    overload_det = 1'b0;
    if (j + 1 < DIV) begin
      nxt(DIV - 1 - (j + 1));
      chk("R2 no early trip", out_enable, 1);
      nxt(1);
    end
    chk("R1 R2 trip at next tick", out_enable, 0);
    chk("R2 flag with trip", overload_flag, 1);
  endtask

  initial begin
    int n;
    logic [15:0] pat;

    // R10 reset state
    overheat_det = 1'b1;
    nxt(3);
    chk("R10 enable in reset", out_enable, 0);
    chk("R10 overload flag in reset", overload_flag, 0);
    chk("R10 overheat flag in reset", overheat_flag, 0);
    overheat_det = 1'b0;
    pwr_enable = 1'b1; supply_good = 1'b1;
    rst_n = 1'b1;
    nxt(1);
    chk("R9 output on after enable", out_enable, 1);

    // persistent overload: repeated hiccup, then release during off
    overload_det = 1'b1;
    run_len(0, 1'b1, n);
    chk("R1 R2 first trip within a tick", (n >= 1 && n <= DIV) ? 1 : 0, 1);
    run_len(0, 1'b0, n);
    chk("R3 off length persistent", n, OFFC);
    run_len(0, 1'b1, n);
    chk("R4 retry length persistent", n, ONC);
    chk("R4 flag during second off", overload_flag, 1);
    nxt(5);
    overload_det = 1'b0;
    run_len(0, 1'b0, n);
    chk("R3 second off length", n, OFFC - 5);
    run_len(1, 1'b1, n);
    chk("R5 clean retry after release", n, ONC);

    // sweep pulse phase across a tick period (R1, R2)
    for (int j = 0; j < DIV; j++) begin
      trip_at(j);
      off_then_clean("phase");
    end

    // sweep a one-cycle pulse across every cycle of the retry window (R4)
    for (int p = 0; p < ONC; p++) begin
      trip_at(0);
      run_len(0, 1'b0, n);
      chk("R3 off before retry", n, OFFC);
      nxt(p);
      overload_det = 1'b1;
      nxt(1);
      overload_det = 1'b0;
      if (p + 1 < ONC) begin
        nxt(ONC - 1 - (p + 1));
        chk("R4 on until window end", out_enable, 1);
        nxt(1);
      end
      chk("R4 pulse in retry retrips", out_enable, 0);
      off_then_clean("retrip");
    end

    // R6 static style follows the comparator
    clamp_static = 1'b1;
    pat = 16'b1011_0010_1110_0101;
    for (int k = 0; k < 16; k++) begin
      overload_det = pat[k];
      nxt(1);
      chk("R6 static output on", out_enable, 1);
      chk("R6 static flag follows", overload_flag, pat[k]);
    end

    // R7 static to dynamic under overload
    overload_det = 1'b1;
    nxt(1);
    clamp_static = 1'b0;
    run_len(0, 1'b1, n);
    chk("R7 trip after switch within a tick", (n >= 1 && n <= DIV) ? 1 : 0, 1);
    chk("R7 flag at trip", overload_flag, 1);
    overload_det = 1'b0;
    off_then_clean("R7");

    // R7 dynamic to static during off window
    trip_at(0);
    nxt(7);
    clamp_static = 1'b1;
    nxt(1);
    chk("R7 static restores output", out_enable, 1);
    chk("R7 static flag follows clear input", overload_flag, 0);
    nxt(OFFC);
    chk("R7 no hiccup resumes in static", out_enable, 1);
    clamp_static = 1'b0;
    nxt(2 * OFFC);
    chk("R7 dynamic without overload stays on", out_enable, 1);
    resync();

    // R8 overheat in the middle of an off window
    trip_at(0);
    nxt(10);
    overheat_det = 1'b1;
    nxt(1);
    chk("R8 heat output off", out_enable, 0);
    chk("R8 heat flag set", overheat_flag, 1);
    chk("R8 overload flag cleared", overload_flag, 0);
    clamp_static = 1'b1;
    overload_det = 1'b1;
    nxt(4);
    chk("R8 heat beats static", out_enable, 0);
    clamp_static = 1'b0;
    overload_det = 1'b0;
    overheat_det = 1'b0;
    nxt(1);
    chk("R8 heat release output on", out_enable, 1);
    chk("R8 heat flag cleared", overheat_flag, 0);
    nxt(2 * OFFC);
    chk("R8 sequence was reset", out_enable, 1);
    resync();

    // R9 enable and supply loss
    trip_at(0);
    nxt(10);
    pwr_enable = 1'b0;
    overheat_det = 1'b1;
    nxt(1);
    chk("R9 disable output off", out_enable, 0);
    chk("R9 disable flag clear", overload_flag, 0);
    chk("R9 heat flag tracks while disabled", overheat_flag, 1);
    overheat_det = 1'b0;
    nxt(1);
    pwr_enable = 1'b1;
    nxt(1);
    chk("R9 re-enable output on", out_enable, 1);
    nxt(2 * OFFC);
    chk("R9 sequence was reset", out_enable, 1);
    supply_good = 1'b0;
    nxt(1);
    chk("R9 supply loss output off", out_enable, 0);
    supply_good = 1'b1;
    nxt(1);
    chk("R9 supply back output on", out_enable, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule